// File: doc/BRIEF.md
# Packed Mixed-Sign Saturating Accumulator

This block is a lane array that adds unsigned source elements to signed accumulator elements packed in a 128-bit word. It writes back the clamped signed sums. A 2-bit size code selects the element width at run time. A mode bit chooses between a single scalar element and a packed vector, and in vector mode a width bit selects 64 or 128 active bits.

Each lane forms the exact sum with two spare bits, so 64-bit lanes keep their carry. A lane that exceeds its signed range clamps to the range limit. A sticky saturation flag gathers overflow from every active lane until a clear input resets it. One configuration is reserved: 64-bit elements in a 64-bit vector. It raises an error flag and leaves the result and the saturation flag unchanged.

Top module: `mixsat_acc`

## Requirements
- R1: The element width is 8 << sizeCode (sizeCode 0..3 gives 8, 16, 32 or 64 bits). In vector mode (scalarMode=0) the active width is 64 bits when wideSel=0 and 128 bits when wideSel=1. The lane count is the active width divided by the element width, and lane k occupies bits [k*w +: w].
- R2: In each active lane the source element is read as unsigned and the accumulator element as two's-complement. When the exact sum fits the signed range, the lane result is that sum, including sums with a negative accumulator.
- R3: On a valid cycle with scalarMode=0, wideSel=0 and sizeCode=3, cfgErrOut becomes 1 and neither resultOut nor satFlagOut changes. Any other valid cycle sets cfgErrOut to 0.
- R4: A lane whose exact sum exceeds the signed maximum for its width produces that maximum, 0 followed by w-1 ones.
- R5: In scalar mode (scalarMode=1) exactly one element, in the lowest w bits, is processed, and every result bit above it is 0. All four size codes are legal in this mode.
- R6: In 64-bit vector mode, result bits 127:64 are 0.
- R7: satFlagOut is set when any active lane saturates. Source and accumulator bits outside the active width never set it.
- R8: Once set, satFlagOut stays 1 through later operations that do not saturate, until it is cleared.
- R9: satClr resets satFlagOut on the next edge, whether or not a valid cycle occurs. It takes priority over a saturation in the same cycle.
- R10: resultOut and cfgErrOut update only on an edge where validIn is 1, with one cycle of latency. Otherwise they hold.
- R11: After reset, resultOut, cfgErrOut and satFlagOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operation strobe |
| srcIn | input | 128 | Unsigned source elements |
| accIn | input | 128 | Signed accumulator elements |
| sizeCode | input | 2 | Element width code |
| wideSel | input | 1 | Vector width select (0: 64 bits, 1: 128 bits) |
| scalarMode | input | 1 | 1: single element, 0: packed vector |
| satClr | input | 1 | Synchronous clear of the saturation flag |
| resultOut | output | 128 | Registered lane results |
| cfgErrOut | output | 1 | Reserved configuration seen on the last valid cycle |
| satFlagOut | output | 1 | Sticky cumulative saturation flag |

## Verification
The result, the error flag and the saturation flag all appear one clock after the edge that samples the operation. No combinational path reaches an output. The bench drives every input on a falling edge and holds validIn for one cycle. It then compares all three outputs on the following falling edge, half a cycle after the edge that registered them, against a running model that carries the previous result across reserved and idle cycles. Idle cycles scramble the data inputs and recheck that the outputs are unchanged.

// File: rtl/mixacc_pkg.sv
package mixacc_pkg;
  localparam int DATA_W      = 128;
  localparam int SIZE_CODE_W = 2;
  localparam int NUM_SIZES   = 1 << SIZE_CODE_W;
  localparam int MIN_EW      = 8;
  localparam int MAX_LANES   = DATA_W / MIN_EW;
  localparam int LANE_CNT_W  = $clog2(MAX_LANES + 1);

  typedef struct packed {
    logic loadRes;   // commit datapath result
    logic latchErr;  // update error flag
    logic cfgErr;    // reserved configuration value
    logic clrSat;    // clear sticky flag
  } accStrobeT;
endpackage

// File: rtl/mixacc_lane.sv
module mixacc_lane #(
  parameter int EW = 8
) (
  input  logic [EW-1:0] uIn,
  input  logic [EW-1:0] sIn,
  output logic [EW-1:0] laneRes,
  output logic          laneSat
);
  localparam int SW = EW + 2;
  localparam logic signed [SW-1:0] MAXV = {3'b000, {(EW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {3'b111, {(EW-1){1'b0}}};

  logic signed [SW-1:0] exactSum;
  logic overHi, overLo;

  always_comb begin
    exactSum = $signed({2'b00, uIn}) + $signed({{2{sIn[EW-1]}}, sIn});
    overHi   = exactSum > MAXV;
    overLo   = exactSum < MINV;
    laneSat  = overHi | overLo;
    if (overHi)      laneRes = {1'b0, {(EW-1){1'b1}}};
    else if (overLo) laneRes = {1'b1, {(EW-1){1'b0}}};
    else             laneRes = exactSum[EW-1:0];
  end
endmodule

// File: rtl/mixacc_ctrl.sv
module mixacc_ctrl
  import mixacc_pkg::*;
(
  input  logic                   validIn,
  input  logic [SIZE_CODE_W-1:0] sizeCode,
  input  logic                   wideSel,
  input  logic                   scalarMode,
  input  logic                   satClr,
  output accStrobeT              strobes,
  output logic [LANE_CNT_W-1:0]  laneCnt
);
  localparam logic [LANE_CNT_W-1:0] FULL_LANES = LANE_CNT_W'(MAX_LANES);
  localparam logic [LANE_CNT_W-1:0] HALF_LANES = LANE_CNT_W'(MAX_LANES / 2);

  logic reservedCfg;

  always_comb begin
    reservedCfg = !scalarMode && !wideSel && (sizeCode == SIZE_CODE_W'(NUM_SIZES - 1));
    if (scalarMode) laneCnt = LANE_CNT_W'(1);
    else            laneCnt = (wideSel ? FULL_LANES : HALF_LANES) >> sizeCode;
    strobes.loadRes  = validIn && !reservedCfg;
    strobes.latchErr = validIn;
    strobes.cfgErr   = reservedCfg;
    strobes.clrSat   = satClr;
  end
endmodule

// File: rtl/mixacc_datapath.sv
module mixacc_datapath
  import mixacc_pkg::*;
(
  input  logic [DATA_W-1:0]      srcIn,
  input  logic [DATA_W-1:0]      accIn,
  input  logic [SIZE_CODE_W-1:0] sizeCode,
  input  logic [LANE_CNT_W-1:0]  laneCnt,
  output logic [DATA_W-1:0]      sumOut,
  output logic                   satAny
);
  logic [DATA_W-1:0]    resBySize [NUM_SIZES];
  logic [NUM_SIZES-1:0] satBySize;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : gSize
    localparam int EW = MIN_EW << s;
    localparam int NL = DATA_W / EW;
    logic [DATA_W-1:0] resS;
    logic [NL-1:0]     satS;

    for (genvar l = 0; l < NL; l++) begin : gLane
      localparam logic [LANE_CNT_W-1:0] LIDX = LANE_CNT_W'(l);
      logic [EW-1:0] laneRes;
      logic          laneSat;
      logic          active;

      mixacc_lane #(.EW(EW)) lane_i (
        .uIn     (srcIn[l*EW +: EW]),
        .sIn     (accIn[l*EW +: EW]),
        .laneRes (laneRes),
        .laneSat (laneSat)
      );

      assign active            = LIDX < laneCnt;
      assign resS[l*EW +: EW]  = active ? laneRes : '0;
      assign satS[l]           = active && laneSat;
    end

    assign resBySize[s] = resS;
    assign satBySize[s] = |satS;
  end

  always_comb begin
    sumOut = resBySize[sizeCode];
    satAny = satBySize[sizeCode];
  end
endmodule

// File: rtl/mixsat_acc.sv
module mixsat_acc
  import mixacc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   validIn,
  input  logic [DATA_W-1:0]      srcIn,
  input  logic [DATA_W-1:0]      accIn,
  input  logic [SIZE_CODE_W-1:0] sizeCode,
  input  logic                   wideSel,
  input  logic                   scalarMode,
  input  logic                   satClr,
  output logic [DATA_W-1:0]      resultOut,
  output logic                   cfgErrOut,
  output logic                   satFlagOut
);
  accStrobeT               strobes;
  logic [LANE_CNT_W-1:0]   laneCnt;
  logic [DATA_W-1:0]       sumVal;
  logic                    satAny;

  mixacc_ctrl ctrl_i (
    .validIn    (validIn),
    .sizeCode   (sizeCode),
    .wideSel    (wideSel),
    .scalarMode (scalarMode),
    .satClr     (satClr),
    .strobes    (strobes),
    .laneCnt    (laneCnt)
  );

  mixacc_datapath dp_i (
    .srcIn    (srcIn),
    .accIn    (accIn),
    .sizeCode (sizeCode),
    .laneCnt  (laneCnt),
    .sumOut   (sumVal),
    .satAny   (satAny)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut  <= '0;
      cfgErrOut  <= 1'b0;
      satFlagOut <= 1'b0;
    end else begin
      if (strobes.loadRes)  resultOut <= sumVal;
      if (strobes.latchErr) cfgErrOut <= strobes.cfgErr;
      if (strobes.clrSat)                     satFlagOut <= 1'b0;
      else if (strobes.loadRes && satAny)     satFlagOut <= 1'b1;
    end
  end
endmodule

// File: rtl/mixsat_acc_chk.sv
module mixsat_acc_chk
  import mixacc_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   validIn,
  input logic [SIZE_CODE_W-1:0] sizeCode,
  input logic                   wideSel,
  input logic                   scalarMode,
  input logic                   satClr,
  input logic [DATA_W-1:0]      resultOut,
  input logic                   cfgErrOut,
  input logic                   satFlagOut
);
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !satClr && !scalarMode && !wideSel && sizeCode == 2'd3)
      |=> (cfgErrOut && $stable(resultOut) && $stable(satFlagOut))); // R3

  AST_SCALAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && scalarMode && sizeCode == 2'd0) |=> (resultOut[DATA_W-1:8] == '0)); // R5

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !scalarMode && !wideSel && sizeCode != 2'd3)
      |=> (resultOut[DATA_W-1:DATA_W/2] == '0)); // R6

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satFlagOut && !satClr) |=> satFlagOut); // R8

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    satClr |=> !satFlagOut); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(resultOut) && $stable(cfgErrOut))); // R10
endmodule

bind mixsat_acc mixsat_acc_chk chk_i (.*);

// File: tb/mixsat_acc_tb_top.sv
`timescale 1ns/1ps
module mixsat_acc_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [127:0] srcIn = '0;
  logic [127:0] accIn = '0;
  logic [1:0]   sizeCode = '0;
  logic         wideSel = 1'b0;
  logic         scalarMode = 1'b0;
  logic         satClr = 1'b0;
  logic [127:0] resultOut;
  logic         cfgErrOut;
  logic         satFlagOut;

  int checks = 0;
  int failures = 0;
  logic [127:0] expRes = '0;
  logic         expErr = 1'b0;
  logic         expSat = 1'b0;

  always #10 clk = ~clk;

  mixsat_acc dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .srcIn(srcIn), .accIn(accIn),
    .sizeCode(sizeCode), .wideSel(wideSel), .scalarMode(scalarMode), .satClr(satClr),
    .resultOut(resultOut), .cfgErrOut(cfgErrOut), .satFlagOut(satFlagOut)
  );

  // returns {saturated, result}
  function automatic logic [128:0] model(input logic [127:0] s, input logic [127:0] a,
                                         input logic [1:0] sz, input logic wd, input logic sc);
    int ew = 8 << sz;
    int n = sc ? 1 : ((wd ? 128 : 64) / ew);
    logic [127:0] r = '0;
    logic sat = 1'b0;
    logic [65:0] mask = (ew == 64) ? {2'b00, {64{1'b1}}} : ((66'd1 << ew) - 66'd1);
    for (int l = 0; l < n; l++) begin
      logic [63:0] uE = 64'(s >> (l * ew));
      logic [63:0] aE = 64'(a >> (l * ew));
      logic signed [65:0] uS = $signed({2'b00, uE} & mask);
      logic signed [65:0] aS = $signed({2'b00, aE} & mask);
      logic signed [65:0] mx = (66'sd1 <<< (ew - 1)) - 66'sd1;
      logic signed [65:0] mn = -(66'sd1 <<< (ew - 1));
      logic signed [65:0] sm;
      logic signed [65:0] cl;
      if (aE[ew-1]) aS = aS | $signed(~mask);
      sm = uS + aS;
      if (sm > mx)      begin cl = mx; sat = 1'b1; end
      else if (sm < mn) begin cl = mn; sat = 1'b1; end
      else              cl = sm;
      for (int b = 0; b < ew; b++) r[l*ew + b] = cl[b];
    end
    return {sat, r};
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(resultOut === expRes, {req, " result"}, resultOut, expRes);
    check(cfgErrOut === expErr, {req, " cfgErr"}, 128'(cfgErrOut), 128'(expErr));
    check(satFlagOut === expSat, {req, " satFlag"}, 128'(satFlagOut), 128'(expSat));
  endtask

  task automatic doOp(input logic [127:0] s, input logic [127:0] a, input logic [1:0] sz,
                      input logic wd, input logic sc, input logic clr, input string req);
    logic [128:0] m = model(s, a, sz, wd, sc);
    logic rsv = !sc && !wd && sz == 2'd3;
    @(negedge clk);
    srcIn = s; accIn = a; sizeCode = sz; wideSel = wd; scalarMode = sc;
    satClr = clr; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0; satClr = 1'b0;
    expErr = rsv;
    if (!rsv) expRes = m[127:0];
    if (clr) expSat = 1'b0;
    else if (!rsv && m[128]) expSat = 1'b1;
    checkAll(req);
  endtask

  task automatic doIdle(input logic clr, input string req);
    @(negedge clk);
    srcIn = {4{$urandom}}; accIn = {4{$urandom}}; sizeCode = 2'($urandom);
    wideSel = 1'($urandom); scalarMode = 1'($urandom); satClr = clr; validIn = 1'b0;
    @(negedge clk);
    satClr = 1'b0;
    if (clr) expSat = 1'b0;
    checkAll(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    checkAll("R11 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R11 after release");

    // R1 R2: 8-bit lanes across 128 bits, negative accumulators
    doOp({16{8'h05}}, {16{8'hF0}}, 2'd0, 1'b1, 1'b0, 1'b0, "R1 R2 byte lanes");
    check(resultOut[7:0] === 8'hF5, "R2 neg acc", 128'(resultOut[7:0]), 128'hF5);
    // R2: negative accumulator plus large unsigned, in range
    doOp({8{16'hFFFF}}, {8{16'h8000}}, 2'd1, 1'b1, 1'b0, 1'b0, "R2 large unsigned");
    check(resultOut[15:0] === 16'h7FFF, "R2 exact max", 128'(resultOut[15:0]), 128'h7FFF);
    // R4 R7: 64-bit scalar saturation
    doOp({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h0000_0000_0000_0001}, 2'd3, 1'b0, 1'b1, 1'b0, "R4 R7 scalar 64");
    check(resultOut[63:0] === 64'h7FFF_FFFF_FFFF_FFFF, "R4 clamp", 128'(resultOut[63:0]), 128'h7FFF_FFFF_FFFF_FFFF);
    // R8: sticky across non-saturating op
    doOp(128'h1, 128'h1, 2'd2, 1'b1, 1'b0, 1'b0, "R8 sticky");
    // R9: clear without valid
    doIdle(1'b1, "R9 clear idle");
    // R9: clear wins over saturation in the same cycle
    doOp({16{8'hFF}}, {16{8'h7F}}, 2'd0, 1'b1, 1'b0, 1'b1, "R9 clear priority");
    // R3: reserved leaves result and flag untouched
    doOp({16{8'hFF}}, {16{8'h7F}}, 2'd3, 1'b0, 1'b0, 1'b0, "R3 reserved");
    doOp(128'h3, 128'h4, 2'd3, 1'b1, 1'b0, 1'b0, "R3 err clears");
    // R6 R7: upper half would saturate but is inactive
    doOp({{8{8'hFF}}, {8{8'h01}}}, {{8{8'h7F}}, {8{8'h02}}}, 2'd0, 1'b0, 1'b0, 1'b0, "R6 R7 narrow");
    // R5: scalar byte, upper bits zero
    doOp({128{1'b1}}, {128{1'b1}}, 2'd0, 1'b0, 1'b1, 1'b0, "R5 scalar byte");
    // R10: idle cycles hold outputs
    doIdle(1'b0, "R10 idle hold");
    doIdle(1'b0, "R10 idle hold 2");

    for (int i = 0; i < 400; i++) begin
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(3) == 0) s = s | {16{8'hC0}};
      if ($urandom_range(3) == 0) a = a & {16{8'h7F}};
      doOp(s, a, 2'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(7) == 0, "R1 R2 R4 R7 random");
      if ($urandom_range(9) == 0) doIdle(1'($urandom), "R10 R9 random idle");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule